// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block collects up to eight interrupt request lines, latches their rising edges, masks and ranks them, and presents a single interrupt line to the processor. When the processor acknowledges, the controller answers with a byte vector for the winning input and marks that input as in service until software retires it. Reaching the controller takes two byte addresses: a command address and a data address.

After reset, software programs the controller with an initialization word sequence. The sequence sets the vector base, the cascade wiring and the end-of-interrupt style. At run time, software uses the command address to retire in-service inputs and to choose which register a command-address read returns. A data-address write changes the mask.

In a cascaded system, one instance runs as master and others run as slaves. When the master acknowledges an input that has a slave behind it, it publishes that input number on the cascade output and does not drive a vector. A slave answers an acknowledge only when the cascade input carries its own identity. The role is chosen by a pin.

Top module: `pic_top`

## Requirements
- R1: A command-address write with bit 4 set starts initialization. It clears the mask, returns the read select to the request register and clears automatic end-of-interrupt. Bit 1 of that word means "single, no cascade word" and bit 0 means "mode word follows". The following data-address writes are taken in turn as the base word, then the cascade word (only if bit 1 was clear), then the mode word (only if bit 0 was set). After that, data-address writes load the mask again.
- R2: The vector delivered for input n is the base word with its low three bits replaced by n.
- R3: In master role with cascading, acknowledging input n whose bit is set in the cascade word pulses cas_en_o for one cycle with cas_o = n, and vec_valid_o stays low. In slave role, an acknowledge is answered only when cas_i equals the low three bits of the cascade word.
- R4: When bit 1 of the mode word is set, an acknowledge leaves the in-service register unchanged.
- R5: A command write of 0x60 + n (n = 0..7) clears in-service bit n.
- R6: A command write of 0x0B makes command-address reads return the in-service register. A command write of 0x0A makes them return the request register. A data-address read returns the mask.
- R7: A data-address write outside initialization loads the mask; a set bit keeps that input from raising int_o.
- R8: An acknowledge with no eligible request delivers the vector for input 7 and leaves the in-service register unchanged.
- R9: int_o is high only when there is an unmasked pending input whose index is lower than every in-service bit. The lowest such index is served first.
- R10: A request bit is set by a rising edge of its input. It is cleared when the input falls, and it is cleared when its acknowledge is accepted.
- R11: After reset, the mask is 0xFF, the request and in-service registers are zero, int_o is low and command reads return the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = command address, 1 = data address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for addr_i |
| irq_i | input | 8 | Interrupt request lines |
| role_master_i | input | 1 | 1 = master role, 0 = slave role |
| int_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| cas_i | input | 3 | Cascade identity seen by a slave |
| cas_o | output | 3 | Cascade input number published by a master |
| cas_en_o | output | 1 | cas_o valid for one cycle |
| vec_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | vec_o valid for one cycle after acknowledge |

## Verification
The bench builds the block with its default parameters: eight inputs, byte-wide registers and a three-bit cascade identity. With these values, every encoding that is fixed to the command byte and every input index can be reached. Random phases in single mode, run once with normal and once with automatic end-of-interrupt, mix edges, drops, acknowledges and retirements. This exercises priority nesting under random masks and spurious vectors. Directed cases cover the cascade routing, the slave identity match and the short initialization sequences.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_READY,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE
  } init_state_e;

  localparam logic [2:0] OP_SPEC_EOI = 3'b011;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_IN = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_IN-1:0]   imr_o,
  output logic [DW-1:IDX_W] base_hi_o,
  output logic [DW-1:0]     cas_cfg_o,
  output logic              single_o,
  output logic              aeoi_o,
  output logic              rd_isr_o,
  output logic              eoi_valid_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  init_state_e         state_q;
  logic [N_IN-1:0]     imr_q;
  logic [DW-1:IDX_W]   base_q;
  logic [DW-1:0]       cas_q;
  logic                single_q, need_mode_q, aeoi_q, rd_isr_q;
  logic                cmd_wr, dat_wr, init_start, ocw3_wr;

  assign cmd_wr     = wr_en_i & ~addr_i;
  assign dat_wr     = wr_en_i & addr_i;
  assign init_start = cmd_wr & wdata_i[4];
  assign ocw3_wr    = cmd_wr & (wdata_i[4:3] == 2'b01) & (state_q == SEQ_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_READY;
      imr_q       <= '1;
      base_q      <= '0;
      cas_q       <= '0;
      single_q    <= 1'b1;
      need_mode_q <= 1'b0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
    end else if (init_start) begin
      state_q     <= SEQ_BASE;
      imr_q       <= '0;
      rd_isr_q    <= 1'b0;
      aeoi_q      <= 1'b0;
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
    end else if (dat_wr) begin
      unique case (state_q)
        SEQ_READY: imr_q <= wdata_i[N_IN-1:0];
        SEQ_BASE: begin
          base_q <= wdata_i[DW-1:IDX_W];
          if (!single_q)       state_q <= SEQ_CASC;
          else if (need_mode_q) state_q <= SEQ_MODE;
          else                 state_q <= SEQ_READY;
        end
        SEQ_CASC: begin
          cas_q   <= wdata_i;
          state_q <= need_mode_q ? SEQ_MODE : SEQ_READY;
        end
        SEQ_MODE: begin
          aeoi_q  <= wdata_i[1];
          state_q <= SEQ_READY;
        end
        default: state_q <= SEQ_READY;
      endcase
    end else if (ocw3_wr && wdata_i[1]) begin
      rd_isr_q <= wdata_i[0];
    end
  end

  assign eoi_valid_o = cmd_wr & (wdata_i[4:3] == 2'b00) &
                       (wdata_i[7:5] == OP_SPEC_EOI) & (state_q == SEQ_READY);
  assign eoi_idx_o   = wdata_i[IDX_W-1:0];
  assign imr_o       = imr_q;
  assign base_hi_o   = base_q;
  assign cas_cfg_o   = cas_q;
  assign single_o    = single_q;
  assign aeoi_o      = aeoi_q;
  assign rd_isr_o    = rd_isr_q;

  assert_init_clears_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start |=> (state_q == SEQ_BASE) && (imr_q == '0) && !rd_isr_q);

  assert_mask_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && state_q == SEQ_READY) |=> imr_q == $past(wdata_i[N_IN-1:0]));

  assert_read_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw3_wr && wdata_i[1]) |=> rd_isr_q == $past(wdata_i[0]));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IN = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  irr_i,
  input  logic [N_IN-1:0]  imr_i,
  input  logic [N_IN-1:0]  isr_i,
  output logic             cand_valid_o,
  output logic [IDX_W-1:0] cand_idx_o
);
  logic shadow;

  // index 0 highest; an in-service bit blocks itself and every lower priority
  always_comb begin
    shadow       = 1'b0;
    cand_valid_o = 1'b0;
    cand_idx_o   = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (isr_i[i]) shadow = 1'b1;
      if (!shadow && !cand_valid_o && irr_i[i] && !imr_i[i]) begin
        cand_valid_o = 1'b1;
        cand_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int DW   = 8,
  parameter int N_IN = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   irq_i,
  input  logic              ack_i,
  input  logic              role_master_i,
  input  logic [IDX_W-1:0]  cas_i,
  input  logic              single_i,
  input  logic [DW-1:0]     cas_cfg_i,
  input  logic              aeoi_i,
  input  logic [DW-1:IDX_W] base_hi_i,
  input  logic              eoi_valid_i,
  input  logic [IDX_W-1:0]  eoi_idx_i,
  input  logic              cand_valid_i,
  input  logic [IDX_W-1:0]  cand_idx_i,
  output logic [N_IN-1:0]   irr_o,
  output logic [N_IN-1:0]   isr_o,
  output logic [DW-1:0]     vec_o,
  output logic              vec_valid_o,
  output logic [IDX_W-1:0]  cas_o,
  output logic              cas_en_o
);
  logic [N_IN-1:0]  irq_q, irr_q, isr_q;
  logic [N_IN-1:0]  rise, take_mask, eoi_mask;
  logic             ack_hit, take, route_slave;
  logic [IDX_W-1:0] sel;
  logic [DW-1:0]    vec_q;
  logic             vec_valid_q, cas_en_q;
  logic [IDX_W-1:0] cas_q;

  assign ack_hit     = ack_i & (role_master_i | single_i | (cas_i == cas_cfg_i[IDX_W-1:0]));
  assign take        = ack_hit & cand_valid_i;
  assign route_slave = take & role_master_i & ~single_i & cas_cfg_i[cand_idx_i];
  assign sel         = cand_valid_i ? cand_idx_i : IDX_W'(N_IN - 1);
  assign rise        = irq_i & ~irq_q;
  assign take_mask   = take ? (N_IN'(1) << cand_idx_i) : '0;
  assign eoi_mask    = eoi_valid_i ? (N_IN'(1) << eoi_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q       <= '0;
      irr_q       <= '0;
      isr_q       <= '0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
      cas_en_q    <= 1'b0;
      cas_q       <= '0;
    end else begin
      irq_q       <= irq_i;
      irr_q       <= (irr_q | rise) & irq_i & ~take_mask;
      isr_q       <= (isr_q & ~eoi_mask) | (aeoi_i ? '0 : take_mask);
      vec_valid_q <= ack_hit & ~route_slave;
      vec_q       <= {base_hi_i, sel};
      cas_en_q    <= route_slave;
      cas_q       <= cand_idx_i;
    end
  end

  assign irr_o       = irr_q;
  assign isr_o       = isr_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;
  assign cas_o       = cas_q;
  assign cas_en_o    = cas_en_q;

  assert_irr_follows_line_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_q & ~irq_q) == '0);

  assert_spurious_keeps_isr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit && !cand_valid_i && !eoi_valid_i) |=> isr_q == $past(isr_q));

  assert_auto_eoi_keeps_isr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && aeoi_i && !eoi_valid_i) |=> isr_q == $past(isr_q));

  assert_spec_eoi_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && !(take && cand_idx_i == eoi_idx_i)) |=> !isr_q[$past(eoi_idx_i)]);

  assert_slave_route_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_slave |=> cas_en_o && !vec_valid_o && (cas_o == $past(cand_idx_i)));
endmodule

// File: rtl/pic_top.sv
module pic_top #(
  parameter int DW   = 8,
  parameter int N_IN = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_IN-1:0]  irq_i,
  input  logic             role_master_i,
  output logic             int_o,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] cas_i,
  output logic [IDX_W-1:0] cas_o,
  output logic             cas_en_o,
  output logic [DW-1:0]    vec_o,
  output logic             vec_valid_o
);
  logic [N_IN-1:0]   imr, irr, isr;
  logic [DW-1:IDX_W] base_hi;
  logic [DW-1:0]     cas_cfg;
  logic              single, aeoi, rd_isr, eoi_valid, cand_valid;
  logic [IDX_W-1:0]  eoi_idx, cand_idx;

  pic_regs #(.DW(DW), .N_IN(N_IN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .imr_o      (imr),
    .base_hi_o  (base_hi),
    .cas_cfg_o  (cas_cfg),
    .single_o   (single),
    .aeoi_o     (aeoi),
    .rd_isr_o   (rd_isr),
    .eoi_valid_o(eoi_valid),
    .eoi_idx_o  (eoi_idx)
  );

  pic_prio #(.N_IN(N_IN)) u_prio (
    .irr_i       (irr),
    .imr_i       (imr),
    .isr_i       (isr),
    .cand_valid_o(cand_valid),
    .cand_idx_o  (cand_idx)
  );

  pic_service #(.DW(DW), .N_IN(N_IN)) u_service (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .ack_i        (ack_i),
    .role_master_i(role_master_i),
    .cas_i        (cas_i),
    .single_i     (single),
    .cas_cfg_i    (cas_cfg),
    .aeoi_i       (aeoi),
    .base_hi_i    (base_hi),
    .eoi_valid_i  (eoi_valid),
    .eoi_idx_i    (eoi_idx),
    .cand_valid_i (cand_valid),
    .cand_idx_i   (cand_idx),
    .irr_o        (irr),
    .isr_o        (isr),
    .vec_o        (vec_o),
    .vec_valid_o  (vec_valid_o),
    .cas_o        (cas_o),
    .cas_en_o     (cas_en_o)
  );

  assign int_o = cand_valid;

  always_comb begin
    if (addr_i)      rdata_o = DW'(imr);
    else if (rd_isr) rdata_o = DW'(isr);
    else             rdata_o = DW'(irr);
  end

  assert_int_needs_unmasked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr & ~imr) != '0);

  assert_int_above_service_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !isr[cand_idx]);
endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/100ps
module tb_pic_top;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, addr_i = 1'b0, role_master_i = 1'b1, ack_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [2:0] cas_i = '0;
  logic [7:0] rdata_o, vec_o;
  logic       int_o, cas_en_o, vec_valid_o;
  logic [2:0] cas_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_irr, m_isr, m_imr, m_irq_q, m_base;
  logic       m_aeoi, exp_vv;
  logic [7:0] exp_vec;
  int         exp_cand;

  always #2.5 clk = ~clk;

  pic_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i),
    .role_master_i(role_master_i), .int_o(int_o), .ack_i(ack_i),
    .cas_i(cas_i), .cas_o(cas_o), .cas_en_o(cas_en_o),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a;
    #0.5 d = rdata_o;
    addr_i = 1'b0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic isr_read(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    wr(1'b0, 8'h0A);
  endtask

  // reference: lowest unmasked pending index above every in-service bit
  function automatic int ref_cand(input logic [7:0] irr, input logic [7:0] imr, input logic [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return -1;
      if (irr[i] && !imr[i]) return i;
    end
    return -1;
  endfunction

  task automatic rand_phase(input logic aeoi_mode, input int steps);
    logic [7:0] flip, take_m, rise, eoi_m, nirq;
    logic       a, e;
    int         eidx;
    irq_i = '0;
    repeat (3) cyc();
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    wr(1'b1, aeoi_mode ? 8'h03 : 8'h01);
    for (int k = 0; k < 8; k++) wr(1'b0, 8'h60 + 8'(k));
    m_imr = 8'($urandom) & 8'($urandom);
    wr(1'b1, m_imr);
    m_irr = '0; m_isr = '0; m_irq_q = '0; m_base = 8'h40; m_aeoi = aeoi_mode;
    for (int s = 0; s < steps; s++) begin
      flip = 8'($urandom) & 8'($urandom) & 8'($urandom);
      nirq = irq_i ^ flip;
      a    = ($urandom % 4) == 0;
      e    = ($urandom % 3) == 0;
      eidx = $urandom % 8;
      irq_i = nirq; ack_i = a;
      if (e) begin wr_en_i = 1'b1; addr_i = 1'b0; wdata_i = 8'h60 + 8'(eidx); end
      @(posedge clk);
      exp_cand = ref_cand(m_irr, m_imr, m_isr);
      take_m   = (a && exp_cand >= 0) ? (8'd1 << exp_cand) : 8'h00;
      exp_vv   = a;
      exp_vec  = {m_base[7:3], (exp_cand >= 0) ? 3'(exp_cand) : 3'd7};
      rise     = nirq & ~m_irq_q;
      eoi_m    = e ? (8'd1 << eidx) : 8'h00;
      m_isr    = (m_isr & ~eoi_m) | (m_aeoi ? 8'h00 : take_m);
      m_irr    = (m_irr | rise) & nirq & ~take_m;
      m_irq_q  = nirq;
      @(negedge clk);
      ack_i = 1'b0; wr_en_i = 1'b0;
      chk("R9 random int_o", {7'd0, int_o}, {7'd0, (ref_cand(m_irr, m_imr, m_isr) >= 0)});
      chk("R10 random request register", rdata_o, m_irr);
      chk("R2 random vec_valid", {7'd0, vec_valid_o}, {7'd0, exp_vv});
      if (exp_vv) chk(exp_cand >= 0 ? "R2 random vector" : "R8 random spurious vector", vec_o, exp_vec);
    end
    irq_i = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();

    // R11 reset state
    chk("R11 int_o after reset", {7'd0, int_o}, 8'h00);
    rd(1'b1, d); chk("R11 mask after reset", d, 8'hFF);
    rd(1'b0, d); chk("R11 request register after reset", d, 8'h00);

    // R1 / R3 master with slave on input 2
    role_master_i = 1'b1;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R1 init clears mask", d, 8'h00);
    irq_i[2] = 1'b1; cyc();
    chk("R9 int_o on cascade input", {7'd0, int_o}, 8'h01);
    ack();
    chk("R3 cas_en_o pulse", {7'd0, cas_en_o}, 8'h01);
    chk("R3 cas_o number", {5'd0, cas_o}, 8'h02);
    chk("R3 no master vector", {7'd0, vec_valid_o}, 8'h00);
    cyc();
    chk("R3 cas_en_o one cycle", {7'd0, cas_en_o}, 8'h00);
    isr_read(d); chk("R6 in-service read", d, 8'h04);
    rd(1'b0, d); chk("R10 request cleared by acknowledge", d, 8'h00);
    wr(1'b0, 8'h62);
    isr_read(d); chk("R5 specific EOI clears bit 2", d, 8'h00);
    irq_i[2] = 1'b0;

    irq_i[6] = 1'b1; cyc();
    ack();
    chk("R2 vector input 6", vec_o, 8'h26);
    chk("R3 non-cascade input gives vector", {7'd0, vec_valid_o}, 8'h01);
    wr(1'b0, 8'h66); irq_i[6] = 1'b0;

    // R9 nesting
    irq_i[3] = 1'b1; cyc(); ack();
    chk("R2 vector input 3", vec_o, 8'h23);
    irq_i[5] = 1'b1; cyc();
    chk("R9 lower priority blocked", {7'd0, int_o}, 8'h00);
    irq_i[1] = 1'b1; cyc();
    chk("R9 higher priority passes", {7'd0, int_o}, 8'h01);
    ack(); chk("R9 vector input 1", vec_o, 8'h21);
    wr(1'b0, 8'h61); wr(1'b0, 8'h63);
    chk("R9 pending after retire", {7'd0, int_o}, 8'h01);
    ack(); chk("R9 vector input 5", vec_o, 8'h25);
    wr(1'b0, 8'h65);
    irq_i = '0; cyc();

    // R7 masking
    wr(1'b1, 8'hFF);
    irq_i[4] = 1'b1; cyc();
    chk("R7 masked input holds int_o low", {7'd0, int_o}, 8'h00);
    rd(1'b0, d); chk("R10 masked request latched", d, 8'h10);
    wr(1'b1, 8'hEF);
    chk("R7 unmask raises int_o", {7'd0, int_o}, 8'h01);
    rd(1'b1, d); chk("R6 data read returns mask", d, 8'hEF);
    irq_i[4] = 1'b0; cyc();
    chk("R10 falling input drops request", {7'd0, int_o}, 8'h00);

    // R8 spurious
    wr(1'b1, 8'h00);
    irq_i[5] = 1'b1; cyc();
    irq_i[5] = 1'b0; cyc();
    ack();
    chk("R8 spurious vector", vec_o, 8'h27);
    chk("R8 spurious vector valid", {7'd0, vec_valid_o}, 8'h01);
    isr_read(d); chk("R8 spurious leaves in-service clear", d, 8'h00);

    // R4 automatic EOI
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h03);
    irq_i[0] = 1'b1; cyc(); ack();
    chk("R4 vector input 0", vec_o, 8'h20);
    isr_read(d); chk("R4 no in-service bit", d, 8'h00);
    irq_i[0] = 1'b0; cyc();

    // R1 short sequence: single, no mode word
    wr(1'b0, 8'h12); wr(1'b1, 8'h80); wr(1'b1, 8'h5A);
    rd(1'b1, d); chk("R1 third write loads mask", d, 8'h5A);
    irq_i[0] = 1'b1; cyc(); ack();
    chk("R2 new base vector", vec_o, 8'h80);
    isr_read(d); chk("R1 init cleared automatic EOI", d, 8'h01);
    wr(1'b0, 8'h60); irq_i[0] = 1'b0; cyc();

    // R3 slave identity
    role_master_i = 1'b0;
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    irq_i[4] = 1'b1; cyc();
    cas_i = 3'd3; ack();
    chk("R3 slave ignores other identity", {7'd0, vec_valid_o}, 8'h00);
    rd(1'b0, d); chk("R3 request kept after foreign acknowledge", d, 8'h10);
    cas_i = 3'd2; ack();
    chk("R3 slave answers own identity", {7'd0, vec_valid_o}, 8'h01);
    chk("R2 slave vector", vec_o, 8'h2C);
    wr(1'b0, 8'h64); irq_i = '0; cas_i = '0; cyc();
    role_master_i = 1'b1;

    rand_phase(1'b0, 400);
    rand_phase(1'b1, 400);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule